// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Controller

This block turns a group of already-synchronized input pins into one interrupt request per channel. Each channel runs in one of two modes. In edge mode, sticky flags record rising and falling transitions, and enables choose which flags raise the request. In level mode, the request follows the pin directly, with a polarity bit that selects high-active or low-active.

Software drives the block through a word-addressed register port. The port has a single-cycle write strobe and a combinational read path. Both enable registers have write-one-to-set and write-one-to-clear aliases. Writing a one to the status register has a different effect in each mode. For an edge channel it clears the channel's edge flags. For a level channel it flips the channel's active level, so a handler can rearm for the opposite level.

A select input can replace the request outputs with an externally computed match vector.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero. With pins held low, `irq` is zero.
- R2: The mode register (byte offset 0x00) holds one bit per channel in bits NCH-1:0. A bit of 1 makes the channel level-sensitive and 0 makes it edge-sensitive. It changes only on a write to its own offset.
- R3: The rising/level enable register (0x04) is read-write. A one written to its set alias (0x08) sets the matching bit, and a one written to its clear alias (0x0C) clears it. A zero written to either alias leaves the bit unchanged. Without a write, the register holds its value.
- R4: The falling/polarity register (0x10) is read-write, with a set alias at 0x14 and a clear alias at 0x18, both working as in R3. In edge mode, a 1 enables falling-edge requests. In level mode, a 1 selects active-high and a 0 selects active-low.
- R5: The rising-edge flags (0x1C) and falling-edge flags (0x20) compare each pin with its sample from the previous clock, and set one clock after the edge. Writing a one to a flag bit clears it. If an edge and a clear arrive in the same cycle, the flag ends up set. Without an edge or a write, the flags hold.
- R6: An edge-mode channel requests when (its rising flag AND its rising enable) OR (its falling flag AND its falling enable) is true.
- R7: A level-mode channel requests when its rising/level enable is 1 and the pin equals its polarity bit. The request changes combinationally with the pin.
- R8: Reading the status register (0x24) returns the request of every channel.
- R9: Writing a one to a status bit of an edge-mode channel clears both of that channel's edge flags, and leaves its enables unchanged.
- R10: Writing a one to a status bit of a level-mode channel inverts that channel's polarity bit, and leaves the edge flags of edge-mode channels alone.
- R11: The four alias offsets (0x08, 0x0C, 0x14, 0x18) read zero. Bits above NCH-1 read zero. Offsets above 0x24 read zero.
- R12: When `match_sel` is 1, `irq` equals `match_vec`. The status register still reports the internal requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | AW | Byte address; bits 1:0 are ignored |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| pins | input | NCH | Synchronized channel inputs |
| match_sel | input | 1 | 1 selects `match_vec` as the request outputs |
| match_vec | input | NCH | External match vector |
| irq | output | NCH | Interrupt request per channel |

## Verification
The assertions assume that `pins` is already synchronous to `clk`. They also assume that `pins` is low while reset is applied, because the previous-sample register resets to zero and a pin that is high at release would otherwise record a rising edge. The bench drives pins and register writes only just after a falling clock edge and holds all pins at zero throughout reset. Edge-and-clear collisions are produced on purpose, and only in the cycle that tests the priority rule.

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl #(
  parameter int NCH = 8,
  parameter int AW  = 6,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  input  logic [NCH-1:0] pins,
  input  logic           match_sel,
  input  logic [NCH-1:0] match_vec,
  output logic [NCH-1:0] irq
);
  localparam int IW = AW - 2;
  localparam logic [IW-1:0] A_MODE = 0, A_ENR = 1, A_ENR_S = 2, A_ENR_C = 3,
                            A_ENF = 4, A_ENF_S = 5, A_ENF_C = 6,
                            A_RDET = 7, A_FDET = 8, A_STAT = 9;

  logic [NCH-1:0] mode, enr, enf, rflag, fflag, pin_q, req;

  wire [IW-1:0]  idx = addr[AW-1:2];
  wire [NCH-1:0] wd  = wdata[NCH-1:0];
  wire unused_bits   = ^{wdata[DW-1:NCH], addr[1:0]};

  wire w_stat = wr_en && idx == A_STAT;
  wire [NCH-1:0] rise = pins & ~pin_q;
  wire [NCH-1:0] fall = ~pins & pin_q;
  wire [NCH-1:0] st_edge = w_stat ? (wd & ~mode) : '0;
  wire [NCH-1:0] st_lvl  = w_stat ? (wd & mode) : '0;
  wire [NCH-1:0] rclr = ((wr_en && idx == A_RDET) ? wd : '0) | st_edge;
  wire [NCH-1:0] fclr = ((wr_en && idx == A_FDET) ? wd : '0) | st_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= '0;
      enr   <= '0;
      enf   <= '0;
      rflag <= '0;
      fflag <= '0;
      pin_q <= '0;
    end else begin
      pin_q <= pins;
      rflag <= (rflag & ~rclr) | rise;
      fflag <= (fflag & ~fclr) | fall;
      if (wr_en && idx == A_MODE) mode <= wd;
      if (wr_en) begin
        case (idx)
          A_ENR:   enr <= wd;
          A_ENR_S: enr <= enr | wd;
          A_ENR_C: enr <= enr & ~wd;
          A_ENF:   enf <= wd;
          A_ENF_S: enf <= enf | wd;
          A_ENF_C: enf <= enf & ~wd;
          A_STAT:  enf <= enf ^ st_lvl;
          default: ;
        endcase
      end
    end
  end

  assign req = (~mode & ((rflag & enr) | (fflag & enf)))
             | (mode & enr & ~(pins ^ enf));
  assign irq = match_sel ? match_vec : req;

  always_comb begin
    rdata = '0;
    case (idx)
      A_MODE:  rdata[NCH-1:0] = mode;
      A_ENR:   rdata[NCH-1:0] = enr;
      A_ENF:   rdata[NCH-1:0] = enf;
      A_RDET:  rdata[NCH-1:0] = rflag;
      A_FDET:  rdata[NCH-1:0] = fflag;
      A_STAT:  rdata[NCH-1:0] = req;
      default: rdata = '0;
    endcase
  end
endmodule

module pin_irq_chk #(
  parameter int NCH = 8,
  parameter int AW  = 6,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [AW-1:0]  addr,
  input logic [DW-1:0]  rdata,
  input logic [NCH-1:0] pins,
  input logic [NCH-1:0] mode,
  input logic [NCH-1:0] enr,
  input logic [NCH-1:0] enf,
  input logic [NCH-1:0] rflag,
  input logic [NCH-1:0] fflag
);
  logic [NCH-1:0] prv;
  wire [AW-3:0] widx = addr[AW-1:2];
  wire unused_lo = ^addr[1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prv <= '0;
    else        prv <= pins;

  assert_edge_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pins != prv) |=> (((($past(pins) & ~$past(prv)) & ~rflag) == '0) &&
                       (((~$past(pins) & $past(prv)) & ~fflag) == '0)));

  assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && pins == prv) |=> ($stable(rflag) && $stable(fflag)));

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && widx == '0) |=> $stable(mode));

  assert_enable_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(enr) && $stable(enf)));

  assert_alias_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (widx == 2 || widx == 3 || widx == 5 || widx == 6) |-> rdata == '0);

  assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:NCH] == '0);
endmodule

bind pin_irq_ctrl pin_irq_chk #(.NCH(NCH), .AW(AW), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rdata(rdata),
  .pins(pins), .mode(mode), .enr(enr), .enf(enf), .rflag(rflag), .fflag(fflag)
);

// File: tb/test_pin_irq_ctrl.sv
module test_pin_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic clk = 0, rst_n = 0, wr_en = 0, match_sel = 0;
  logic [5:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [NCH-1:0] pins = 0, match_vec = 0, irq;
  int nchk = 0, nfail = 0;
  logic [31:0] r;

  pin_irq_ctrl i_pin_irq_ctrl (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pins(pins), .match_sel(match_sel),
    .match_vec(match_vec), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic setp(input logic [NCH-1:0] v);
    @(negedge clk); pins = v;
    @(posedge clk); #1;
  endtask

  task automatic rchk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    addr = a; #1; chk(tag, rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nfail++; nchk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int a = 0; a < 16; a++) rchk("R1 reset read", 6'(a * 4), 0);
    chk("R1 reset irq", 32'(irq), 0);

    // R2/R3/R4 plain read-write and aliases
    wr(6'h00, 32'hFFFF_FF5A); rchk("R2 mode rw", 6'h00, 32'h5A);
    wr(6'h00, 0);             rchk("R2 mode clear", 6'h00, 0);
    for (int v = 0; v < 256; v += 51) begin
      wr(6'h04, 32'(v)); rchk("R3 enr rw", 6'h04, 32'(v));
      wr(6'h10, 32'(v)); rchk("R4 enf rw", 6'h10, 32'(v));
    end
    wr(6'h04, 32'hA5); wr(6'h08, 32'h0F); rchk("R3 set alias", 6'h04, 32'hAF);
    wr(6'h0C, 32'h81); rchk("R3 clr alias", 6'h04, 32'h2E);
    wr(6'h08, 0); wr(6'h0C, 0); rchk("R3 zero no effect", 6'h04, 32'h2E);
    wr(6'h10, 32'h3C); wr(6'h14, 32'h41); rchk("R4 set alias", 6'h10, 32'h7D);
    wr(6'h18, 32'h0C); rchk("R4 clr alias", 6'h10, 32'h71);
    wr(6'h14, 0); wr(6'h18, 0); rchk("R4 zero no effect", 6'h10, 32'h71);

    // R11 read zero
    rchk("R11 alias 08", 6'h08, 0); rchk("R11 alias 0C", 6'h0C, 0);
    rchk("R11 alias 14", 6'h14, 0); rchk("R11 alias 18", 6'h18, 0);
    rchk("R11 beyond", 6'h28, 0);   rchk("R11 top", 6'h3C, 0);
    wr(6'h04, 0); wr(6'h10, 0);

    // R5/R6/R8/R9 edge mode per channel
    for (int i = 0; i < NCH; i++) begin
      logic [NCH-1:0] b;
      b = NCH'(1) << i;
      setp(b);
      rchk("R5 rise flag", 6'h1C, 32'(b)); rchk("R5 no fall", 6'h20, 0);
      chk("R6 disabled", 32'(irq), 0);
      setp(0);
      rchk("R5 fall flag", 6'h20, 32'(b));
      wr(6'h08, 32'(b)); chk("R6 rise en", 32'(irq), 32'(b));
      rchk("R8 status", 6'h24, 32'(b));
      wr(6'h0C, 32'(b)); chk("R6 rise off", 32'(irq), 0);
      wr(6'h14, 32'(b)); chk("R6 fall en", 32'(irq), 32'(b));
      wr(6'h24, 32'(b));
      rchk("R9 rise cleared", 6'h1C, 0); rchk("R9 fall cleared", 6'h20, 0);
      rchk("R9 enf kept", 6'h10, 32'(b));
      chk("R9 irq off", 32'(irq), 0);
      wr(6'h18, 32'(b));
    end

    // R5 clear-by-write and set priority
    setp(8'h01); setp(8'h00);
    wr(6'h20, 32'h01); rchk("R5 fall clear", 6'h20, 0);
    rchk("R5 rise kept", 6'h1C, 32'h01);
    @(negedge clk); pins = 8'h01; wr_en = 1; addr = 6'h1C; wdata = 32'h01;
    @(posedge clk); #1 wr_en = 0;
    rchk("R5 set wins", 6'h1C, 32'h01);
    wr(6'h1C, 32'h01); rchk("R5 rise clear", 6'h1C, 0);
    setp(0); wr(6'h20, 32'hFF);

    // R7/R8 level sweep
    wr(6'h00, 32'hFF);
    for (int k = 0; k < 3; k++) begin
      logic [NCH-1:0] en, pol;
      en  = (k == 2) ? 8'h55 : 8'hFF;
      pol = (k == 0) ? 8'h00 : 8'h0F;
      wr(6'h04, 32'(en)); wr(6'h10, 32'(pol));
      for (int p = 0; p < 256; p++) begin
        setp(8'(p));
        chk("R7 level irq", 32'(irq), 32'(en & ~(8'(p) ^ pol)));
        rchk("R8 level status", 6'h24, 32'(en & ~(8'(p) ^ pol)));
      end
    end
    @(negedge clk); pins = 8'hA0; #1;
    chk("R7 combinational", 32'(irq), 32'(8'h55 & ~(8'hA0 ^ 8'h0F)));

    // R10 mixed modes status write
    setp(0); wr(6'h1C, 32'hFF); wr(6'h20, 32'hFF);
    wr(6'h00, 32'h0F); wr(6'h04, 0); wr(6'h10, 32'h05);
    setp(8'hF0); setp(8'h00);
    rchk("R5 pre rise", 6'h1C, 32'hF0);
    wr(6'h24, 32'hFF);
    rchk("R10 toggle", 6'h10, 32'h0A);
    rchk("R9 mixed rise", 6'h1C, 0); rchk("R9 mixed fall", 6'h20, 0);
    wr(6'h24, 32'h03); rchk("R10 toggle back", 6'h10, 32'h09);

    // R12 external match
    wr(6'h00, 32'hFF); wr(6'h04, 32'hFF); wr(6'h10, 32'hFF); setp(8'h0F);
    for (int m = 0; m < 256; m += 37) begin
      @(negedge clk); match_sel = 1; match_vec = 8'(m); #1;
      chk("R12 forced irq", 32'(irq), 32'(m));
      rchk("R12 status internal", 6'h24, 32'h0F);
    end
    @(negedge clk); match_sel = 0; #1;
    chk("R12 released", 32'(irq), 32'h0F);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule